// File: doc/BRIEF.md
# Start Trigger Selector and Exporter

This block picks one start-trigger source out of a set of external trigger lines, a software strobe and an always-ready immediate mode. It brings the chosen line into the sample-clock domain, keeps only rising edges whose high phase lasts a programmable number of sample clocks, and hands the generation engine a one-cycle start pulse.

The same event also drives an exported trigger pin. That pin is stretched to a programmable minimum length and can be gated off. A second start output repeats the start pulse after a fixed pipeline latency, for the digital data path.

Top module: `trig_start_sel`

## Requirements
- R1: `src_sel` picks the source with this encoding: 0 immediate, 1 software, 2..3 `fp_trig[0..1]`, 4..5 `conn_trig[0..1]`, 6..13 `bp_trig[0..7]`, 14 `star_trig`, 15 no source. With code 15 no start pulse is ever issued.
- R2: While code 0 is selected, exactly one start pulse is issued, with no input needed. It appears at the first clock edge after reset release, or after the selection moves to 0 from any other code. A cleared select register therefore starts immediately.
- R3: All outputs are low during reset. `start_pulse` lasts exactly one clock cycle.
- R4: An external source triggers only on a rising edge. A line that is already high when it is selected does not trigger until it has been seen low. Holding a line high gives one trigger only.
- R5: External lines pass a two-flop synchronizer. The high phase must be sampled on at least M = max(`min_high`,1) consecutive edges. If the first high sample is at edge P0, `start_pulse` is high after edge P(M+1). A pulse with M-1 samples is ignored.
- R6: The software strobe bypasses the width filter. A strobe present at an edge with code 1 selected gives `start_pulse` after that edge.
- R7: `trig_out` rises with `start_pulse` and stays high for S = max(`stretch_len`,1) cycles. It stays low whenever `export_en` is 0.
- R8: A trigger that arrives while the export stretch is running still produces a start pulse. It neither restarts nor lengthens the stretch.
- R9: `start_delayed` repeats each `start_pulse` exactly DLY (default 40) clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_trig | input | 2 | Front-panel trigger lines |
| conn_trig | input | 2 | Connector trigger input lines |
| bp_trig | input | NBP | Backplane trigger lines |
| star_trig | input | 1 | Star trigger line |
| sw_trig | input | 1 | Software trigger strobe, one cycle |
| src_sel | input | 4 | Source select code |
| min_high | input | CW | Minimum high time in sample clocks |
| stretch_len | input | CW | Export pulse length in sample clocks |
| export_en | input | 1 | Enable for the exported trigger pin |
| start_pulse | output | 1 | One-cycle start to the generation engine |
| start_delayed | output | 1 | Start pulse delayed by DLY cycles |
| trig_out | output | 1 | Stretched exported trigger |

## Verification
The assertions take for granted that the software strobe is never held high for two cycles in a row. One of them relies on that when it claims that start pulses never touch. They also assume that the select code, width and stretch settings change only while no trigger is pending. The directed tasks raise `sw_trig` for a single cycle only, and they change settings only between scenarios, after every stretch and delay window has drained.

// File: rtl/trig_start_sel.sv
module trig_start_sel #(
  parameter int NBP = 8,
  parameter int CW  = 16,
  parameter int DLY = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fp_trig,
  input  logic [1:0]    conn_trig,
  input  logic [NBP-1:0] bp_trig,
  input  logic          star_trig,
  input  logic          sw_trig,
  input  logic [3:0]    src_sel,
  input  logic [CW-1:0] min_high,
  input  logic [CW-1:0] stretch_len,
  input  logic          export_en,
  output logic          start_pulse,
  output logic          start_delayed,
  output logic          trig_out
);
  localparam int NX = 5 + NBP;
  localparam logic [3:0] SEL_IMM  = 4'd0;
  localparam logic [3:0] SEL_SW   = 4'd1;
  localparam logic [3:0] SEL_EXT0 = 4'd2;
  localparam logic [3:0] SEL_EXTN = SEL_EXT0 + 4'(NX);

  logic [NX-1:0]  sync1, sync2;
  logic [3:0]     sel_q, ext_idx;
  logic           run_ok, imm_done, ext_sel, lvl, sel_chg;
  logic           fire_imm, fire_sw, fire_ext, fire;
  logic [CW-1:0]  hi_cnt, x_cnt, min_eff, str_eff;
  logic [DLY-1:0] dly;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {star_trig, bp_trig, conn_trig, fp_trig};
      sync2 <= sync1;
    end
  end

  assign ext_sel = (src_sel >= SEL_EXT0) && (src_sel < SEL_EXTN);
  assign ext_idx = src_sel - SEL_EXT0;
  assign lvl     = ext_sel && sync2[ext_idx];
  assign sel_chg = src_sel != sel_q;
  assign min_eff = (min_high == '0) ? CW'(1) : min_high;
  assign str_eff = (stretch_len == '0) ? CW'(1) : stretch_len;

  assign fire_imm = (src_sel == SEL_IMM) && !imm_done;
  assign fire_sw  = (src_sel == SEL_SW) && sw_trig;
  assign fire_ext = lvl && run_ok && !sel_chg && (hi_cnt == min_eff - CW'(1));
  assign fire     = fire_imm || fire_sw || fire_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= 4'd15;
      run_ok   <= 1'b0;
      imm_done <= 1'b0;
      hi_cnt   <= '0;
    end else begin
      sel_q <= src_sel;
      if (sel_chg)   run_ok <= 1'b0;
      else if (!lvl) run_ok <= 1'b1;
      if (src_sel != SEL_IMM) imm_done <= 1'b0;
      else if (fire_imm)      imm_done <= 1'b1;
      if (sel_chg || !lvl)   hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      x_cnt       <= '0;
      dly         <= '0;
    end else begin
      start_pulse <= fire;
      if (fire && x_cnt == '0) x_cnt <= str_eff;
      else if (x_cnt != '0)    x_cnt <= x_cnt - CW'(1);
      dly <= {dly[DLY-2:0], start_pulse};
    end
  end

  assign trig_out      = export_en && (x_cnt != '0);
  assign start_delayed = dly[DLY-1];
endmodule

// File: rtl/trig_start_sel_chk.sv
module trig_start_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_trig,
  input logic [3:0] src_sel,
  input logic       export_en,
  input logic       start_pulse,
  input logic       trig_out
);
  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  a_r6_sw_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 4'd1 && sw_trig) |=> start_pulse);

  a_r7_export_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && export_en) |-> trig_out);

  a_r1_none_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 4'd15) |=> !start_pulse);
endmodule

bind trig_start_sel trig_start_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .src_sel(src_sel),
  .export_en(export_en), .start_pulse(start_pulse), .trig_out(trig_out)
);

// File: tb/trig_start_sel_test.sv
module trig_start_sel_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fp = '0, conn = '0;
  logic [7:0] bp = '0;
  logic star = 1'b0, sw = 1'b0, en = 1'b1;
  logic [3:0] sel = 4'd15;
  logic [15:0] minh = 16'd1, strl = 16'd1;
  logic sp, sd, to;
  int vectors = 0, miscomp = 0;

  always #2 clk = ~clk;

  trig_start_sel uut (
    .clk(clk), .rst_n(rst_n), .fp_trig(fp), .conn_trig(conn), .bp_trig(bp),
    .star_trig(star), .sw_trig(sw), .src_sel(sel), .min_high(minh),
    .stretch_len(strl), .export_en(en), .start_pulse(sp),
    .start_delayed(sd), .trig_out(to)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(logic act, logic exp, string rq, int i);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s tick %0d actual=%0b expected=%0b", rq, i, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
  endtask

  // p1/p2: start pulse ticks (0 = none); t_from..t_to: trig_out high window
  task automatic watch(int n, int p1, int p2, int t_from, int t_to,
                       int drop, int sw_at, string rq);
    for (int i = 1; i <= n; i++) begin
      tick();
      sw = 1'b0;
      chk(sp, (i == p1) || (i == p2), rq, i);
      chk(to, (t_from > 0) && (i >= t_from) && (i <= t_to), "R7", i);
      chk(sd, (p1 > 0 && i == p1 + 40) || (p2 > 0 && i == p2 + 40), "R9", i);
      if (i == drop) begin fp = '0; conn = '0; bp = '0; star = 1'b0; end
      if (i == sw_at) sw = 1'b1;
    end
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk(sp, 1'b0, "R3 reset", 0);
    chk(to, 1'b0, "R3 reset", 0);
    chk(sd, 1'b0, "R3 reset", 0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_immediate();
    strl = 16'd3; en = 1'b1; sel = 4'd0;
    watch(45, 1, 0, 1, 3, 0, 0, "R2");
    watch(10, 0, 0, 0, 0, 0, 0, "R2 once");
  endtask

  task automatic t_none();
    sel = 4'd15; fp = '1; conn = '1; bp = '1; star = 1'b1;
    watch(12, 0, 0, 0, 0, 4, 0, "R1");
  endtask

  task automatic t_width();
    sel = 4'd2; minh = 16'd3; strl = 16'd2;
    watch(4, 0, 0, 0, 0, 0, 0, "R5 idle");
    fp[0] = 1'b1;
    watch(50, 5, 0, 5, 6, 3, 0, "R5 accept");
    fp[0] = 1'b1;
    watch(12, 0, 0, 0, 0, 2, 0, "R5 short");
  endtask

  task automatic t_rise_only();
    sel = 4'd2; minh = 16'd1;
    fp[0] = 1'b1;
    watch(50, 3, 0, 3, 4, 0, 0, "R4 held");
    fp = '0;
    watch(5, 0, 0, 0, 0, 0, 0, "R4 held");
    sel = 4'd15; bp[3] = 1'b1;
    watch(5, 0, 0, 0, 0, 0, 0, "R4");
    sel = 4'd9;
    watch(10, 0, 0, 0, 0, 0, 0, "R4 prehigh");
    bp = '0;
    watch(5, 0, 0, 0, 0, 0, 0, "R4");
    bp[3] = 1'b1;
    watch(50, 3, 0, 3, 4, 3, 0, "R4 edge");
  endtask

  task automatic t_sources();
    sel = 4'd5; minh = 16'd2;
    watch(4, 0, 0, 0, 0, 0, 0, "R1");
    conn[1] = 1'b1;
    watch(50, 4, 0, 4, 5, 2, 0, "R1 conn1");
    sel = 4'd14; minh = 16'd1;
    watch(4, 0, 0, 0, 0, 0, 0, "R1");
    star = 1'b1;
    watch(50, 3, 0, 3, 4, 3, 0, "R1 star");
  endtask

  task automatic t_software();
    sel = 4'd1; strl = 16'd10; en = 1'b1;
    watch(4, 0, 0, 0, 0, 0, 0, "R6");
    sw = 1'b1;
    watch(50, 1, 5, 1, 10, 0, 4, "R8");
    en = 1'b0; strl = 16'd5; sw = 1'b1;
    watch(45, 1, 0, 0, 0, 0, 0, "R6");
    en = 1'b1; strl = 16'd0; sw = 1'b1;
    watch(45, 1, 0, 1, 1, 0, 0, "R6");
  endtask

  task automatic t_reenter_imm();
    sel = 4'd0; strl = 16'd2;
    watch(45, 1, 0, 1, 2, 0, 0, "R2 reenter");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_immediate();
    t_none();
    t_width();
    t_rise_only();
    t_sources();
    t_software();
    t_reenter_imm();
    summary();
    $finish;
  end
endmodule